// File: doc/BRIEF.md
# Serial Port Clock and Reset Controller

This block sits next to a serial port and owns the clocking and reset wiring of its local bus. Software reaches it through one 64-bit control word, written with a single write strobe and readable at all times. The fields in that word drive two reset lines, one for the port's control logic and one for the UART core. A further field is a conditional clock enable, and software also reads that bit back as the "port enabled" status.

From the free-running I/O clock the block derives a host clock enable. This is a one-cycle pulse that fires once every N I/O clock cycles. N comes from a fixed, non-power-of-two table indexed by a 3-bit select code. The divider has its own reset bit, which holds its counter cleared, and a bypass bit, which lets the full I/O clock rate through. A gate bit must be set before any pulse leaves the block. Software sequences power-up (reset assertion, divider setup, waits, reset release). The block only stores the word and runs the divider correctly.

Top module: `uart_clkrst_ctl`

## Requirements
- R1: After system reset the control word reads 0x0000_0000_1000_0003: both reset bits (bit 0, bit 1) and the divider reset (bit 28) are 1, all enables are 0, and the host clock enable output is low.
- R2: A write stores the defined fields, and the next cycle's readback returns them exactly. The fields are bit 0 control-logic reset, bit 1 UART-core reset, bit 4 conditional clock enable, bits 26:24 divider select, bit 28 divider reset, bit 29 bypass and bit 30 host clock gate.
- R3: Every bit outside the defined fields reads as 0 whatever was written to it.
- R4: Output `ctlRst` follows bit 0, `coreRst` follows bit 1 and `condClkEn` follows bit 4 of the stored word.
- R5: With gate 1, bypass 0 and divider reset 0, select codes 0..7 give ratios 1, 2, 4, 6, 8, 16, 24, 32. The enable pulse is one cycle wide and repeats every ratio cycles.
- R6: While the divider reset bit is 1 (and bypass is 0), no pulse is produced. After a write clears it, the first pulse appears in the ratio-th cycle after the write takes effect.
- R7: With bypass 1 and gate 1, the enable is high on every I/O clock cycle, regardless of select code or divider reset.
- R8: With gate bit 30 at 0, the host clock enable stays low in all modes.
- R9: With select code 0 (ratio 1), gate 1, bypass 0 and divider reset 0, the enable is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Active-low system reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 64 | Write data |
| rdData | output | 64 | Current control word readback |
| ctlRst | output | 1 | Reset for the port control logic |
| coreRst | output | 1 | Reset for the UART core |
| condClkEn | output | 1 | Conditional clock enable and enabled status |
| hostClkEn | output | 1 | Host clock enable pulse |

## Verification
A write lands on the clock edge after the strobe is presented. Readback and the three mirrored outputs are due in the cycle right after that edge, so the bench samples them at the following falling edge. The pulse output is combinational from the counter. When a write clears the divider reset, that first cycle is counted as index 0, and a pulse is expected at every index i where (i mod ratio) equals ratio-1. Over a 96-cycle window, which every ratio divides, the bench counts pulses and records the first pulse index. Each falling edge after the write is one index, so the pulse count and the first index are both compared exactly.

// File: rtl/uccr_pkg.sv
package uccr_pkg;

  localparam int CTL_W = 64;

  localparam int BIT_CTL_RST  = 0;
  localparam int BIT_CORE_RST = 1;
  localparam int BIT_COND_CLK = 4;
  localparam int SEL_LSB      = 24;
  localparam int SEL_W        = 3;
  localparam int BIT_DIV_RST  = 28;
  localparam int BIT_BYPASS   = 29;
  localparam int BIT_HOST_EN  = 30;

  localparam int RATIO_W = 6;

  localparam logic [CTL_W-1:0] DEFINED_MASK =
      (CTL_W'(1) << BIT_CTL_RST) | (CTL_W'(1) << BIT_CORE_RST) |
      (CTL_W'(1) << BIT_COND_CLK) | (CTL_W'(7) << SEL_LSB) |
      (CTL_W'(1) << BIT_DIV_RST) | (CTL_W'(1) << BIT_BYPASS) |
      (CTL_W'(1) << BIT_HOST_EN);

  localparam logic [CTL_W-1:0] RESET_WORD =
      (CTL_W'(1) << BIT_CTL_RST) | (CTL_W'(1) << BIT_CORE_RST) |
      (CTL_W'(1) << BIT_DIV_RST);

  // Strobes from the register control to the divider datapath
  typedef struct packed {
    logic             divHold;
    logic             passThru;
    logic             gateOpen;
    logic [SEL_W-1:0] ratioCode;
  } div_strobe_t;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [SEL_W-1:0] code);
    logic [RATIO_W-1:0] r;
    case (code)
      3'd0:    r = 6'd1;
      3'd1:    r = 6'd2;
      3'd2:    r = 6'd4;
      3'd3:    r = 6'd6;
      3'd4:    r = 6'd8;
      3'd5:    r = 6'd16;
      3'd6:    r = 6'd24;
      default: r = 6'd32;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/uccr_ctl_regs.sv
module uccr_ctl_regs
  import uccr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  output logic [CTL_W-1:0] rdData,
  output logic             ctlRst,
  output logic             coreRst,
  output logic             condClkEn,
  output div_strobe_t      divStrobe
);

  logic [CTL_W-1:0] ctlWord;

  // Only defined fields are stored; reserved bits stay zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlWord <= RESET_WORD;
    end else if (wrEn) begin
      ctlWord <= wrData & DEFINED_MASK;
    end
  end

  assign rdData    = ctlWord;
  assign ctlRst    = ctlWord[BIT_CTL_RST];
  assign coreRst   = ctlWord[BIT_CORE_RST];
  assign condClkEn = ctlWord[BIT_COND_CLK];

  always_comb begin
    divStrobe.divHold   = ctlWord[BIT_DIV_RST];
    divStrobe.passThru  = ctlWord[BIT_BYPASS];
    divStrobe.gateOpen  = ctlWord[BIT_HOST_EN];
    divStrobe.ratioCode = ctlWord[SEL_LSB +: SEL_W];
  end

endmodule

// File: rtl/uccr_clk_div.sv
module uccr_clk_div
  import uccr_pkg::*;
#(
  parameter int CNT_W = RATIO_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  div_strobe_t divStrobe,
  output logic        tickOut
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastIdx;
  logic             wrapNow;

  assign lastIdx = CNT_W'(ratioOf(divStrobe.ratioCode) - RATIO_W'(1));
  // ">=" lets a shrinking ratio wrap at once instead of running to overflow
  assign wrapNow = (cnt >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (divStrobe.divHold) begin
      cnt <= '0;
    end else if (wrapNow) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    if (!divStrobe.gateOpen) begin
      tickOut = 1'b0;
    end else if (divStrobe.passThru) begin
      tickOut = 1'b1;
    end else begin
      tickOut = !divStrobe.divHold && wrapNow;
    end
  end

endmodule

// File: rtl/uart_clkrst_ctl.sv
module uart_clkrst_ctl
  import uccr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  output logic [CTL_W-1:0] rdData,
  output logic             ctlRst,
  output logic             coreRst,
  output logic             condClkEn,
  output logic             hostClkEn
);

  div_strobe_t divStrobe;

  uccr_ctl_regs uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdData    (rdData),
    .ctlRst    (ctlRst),
    .coreRst   (coreRst),
    .condClkEn (condClkEn),
    .divStrobe (divStrobe)
  );

  uccr_clk_div #(.CNT_W(RATIO_W)) uDiv (
    .clk       (clk),
    .rstN      (rstN),
    .divStrobe (divStrobe),
    .tickOut   (hostClkEn)
  );

endmodule

// File: rtl/uccr_checker.sv
module uccr_checker
  import uccr_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CTL_W-1:0] wrData,
  input logic [CTL_W-1:0] rdData,
  input logic             hostClkEn
);

  logic seenEdge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~DEFINED_MASK) == '0); // R3

  AST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && wrEn) |=> rdData == ($past(wrData) & DEFINED_MASK)); // R2

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[BIT_HOST_EN] |-> !hostClkEn); // R8

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[BIT_DIV_RST] && !rdData[BIT_BYPASS]) |-> !hostClkEn); // R6

  AST_BYPASS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[BIT_HOST_EN] && rdData[BIT_BYPASS]) |-> hostClkEn); // R7

  AST_RATIO_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[BIT_HOST_EN] && !rdData[BIT_BYPASS] && !rdData[BIT_DIV_RST] &&
     rdData[SEL_LSB +: SEL_W] == 3'd0) |-> hostClkEn); // R9

endmodule

bind uart_clkrst_ctl uccr_checker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .hostClkEn (hostClkEn)
);

// File: tb/tb_uart_clkrst_ctl.sv
module tb_uart_clkrst_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 96;
  localparam logic [63:0] RST_EXP = 64'h0000_0000_1000_0003;
  localparam logic [63:0] GATE  = 64'h4000_0000;
  localparam logic [63:0] BYP   = 64'h2000_0000;
  localparam logic [63:0] DRST  = 64'h1000_0000;

  // select code, expected ratio (R5 table)
  localparam int RATIO_TBL [8][2] = '{
    '{0, 1}, '{1, 2}, '{2, 4}, '{3, 6}, '{4, 8}, '{5, 16}, '{6, 24}, '{7, 32}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        ctlRst, coreRst, condClkEn, hostClkEn;

  int checks = 0;
  int failures = 0;
  int pulseCnt;
  int firstIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_clkrst_ctl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .ctlRst(ctlRst), .coreRst(coreRst), .condClkEn(condClkEn),
    .hostClkEn(hostClkEn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Write at a falling edge; returns at the falling edge after capture (index 0)
  task automatic writeCtl(input logic [63:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  // Counts pulses over WIN cycles, starting at index 0 (current falling edge)
  task automatic measure();
    pulseCnt = 0;
    firstIdx = -1;
    for (int i = 0; i < WIN; i++) begin
      if (i > 0) @(negedge clk);
      if (hostClkEn) begin
        pulseCnt++;
        if (firstIdx < 0) firstIdx = i;
      end
    end
  endtask

  function automatic logic [63:0] selField(input int code);
    return 64'(code) << 24;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 word", rdData, RST_EXP);
    check("R1 hostClkEn", 64'(hostClkEn), 64'd0);
    // R4 outputs at reset
    check("R4 ctlRst", 64'(ctlRst), 64'd1);
    check("R4 coreRst", 64'(coreRst), 64'd1);
    check("R4 condClkEn", 64'(condClkEn), 64'd0);

    // R3 reserved bits ignored, R2 defined fields kept
    writeCtl('1);
    check("R3 all-ones readback", rdData, 64'h0000_0000_7700_0013);
    writeCtl(64'hFFFF_FFFF_8000_0000);
    check("R3 reserved-only write", rdData, 64'd0);
    check("R8 gate closed", 64'(hostClkEn), 64'd0);
    writeCtl(64'h0000_0000_2500_0012);
    check("R2 readback", rdData, 64'h0000_0000_2500_0012);
    // R4 mirroring
    check("R4 ctlRst low", 64'(ctlRst), 64'd0);
    check("R4 coreRst high", 64'(coreRst), 64'd1);
    check("R4 condClkEn high", 64'(condClkEn), 64'd1);
    writeCtl(64'h0000_0000_0000_0001);
    check("R4 ctlRst high", 64'(ctlRst), 64'd1);
    check("R4 coreRst low", 64'(coreRst), 64'd0);
    check("R4 condClkEn low", 64'(condClkEn), 64'd0);

    // R5 ratio table walk
    for (int k = 0; k < 8; k++) begin
      writeCtl(GATE | DRST | selField(RATIO_TBL[k][0]));
      writeCtl(GATE | selField(RATIO_TBL[k][0]));
      measure();
      check($sformatf("R5 count code %0d", k), 64'(pulseCnt), 64'(WIN / RATIO_TBL[k][1]));
      check($sformatf("R5 first code %0d", k), 64'(firstIdx), 64'(RATIO_TBL[k][1] - 1));
    end

    // R6 divider reset holds, then first pulse after ratio cycles
    writeCtl(GATE | DRST | selField(3));
    measure();
    check("R6 held no pulse", 64'(pulseCnt), 64'd0);
    writeCtl(GATE | selField(3));
    measure();
    check("R6 first after release", 64'(firstIdx), 64'd5);
    check("R6 count after release", 64'(pulseCnt), 64'd16);

    // R7 bypass, divider reset set and slow code
    writeCtl(GATE | BYP | DRST | selField(7));
    measure();
    check("R7 bypass full rate", 64'(pulseCnt), 64'(WIN));

    // R8 gate closed in divide and bypass modes
    writeCtl(selField(0));
    measure();
    check("R8 gate off divide", 64'(pulseCnt), 64'd0);
    writeCtl(BYP | selField(2));
    measure();
    check("R8 gate off bypass", 64'(pulseCnt), 64'd0);

    // R9 ratio one after a slow ratio ran mid-count
    writeCtl(GATE | selField(7));
    repeat (20) @(negedge clk);
    writeCtl(GATE | selField(0));
    measure();
    check("R9 every cycle", 64'(pulseCnt), 64'(WIN));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule